// File: doc/BRIEF.md
# Edge-Pulse Level Link with Width Discriminator

This block moves a single level command across a boundary that can only carry short events. On the sending side, a rising edge of the command starts a fixed-length pulse on a "set" line and a falling edge starts a pulse of the same length on a "reset" line. On the receiving side, each line goes through a width filter. A pulse is accepted only when its line has been high, with the other line low, for a minimum number of consecutive clock cycles. Accepted pulses update a set/reset latch, and the latch output is the rebuilt command level.

A noise input raises both lines together in the same cycle. This stands in for the common-mode disturbance that fast switching transients cause. A cycle in which both lines are high is discarded and breaks any run in progress, so noise can neither move the latch nor help a short pulse qualify. A receive-enable input comes from supply-monitor logic. While it is low, the latch is held at zero and no pulse is taken. After enable returns, the latch keeps its state until the first pulse accepted while enabled. Everything runs on one clock.

Top module: `edge_link_top`

## Requirements
- R1: While reset is asserted (rstN low) and directly after it, levelOut, linkSet and linkReset are all 0.
- R2: A rising edge of cmdIn, seen at clock edge k, drives linkSet high for exactly PULSE_CYCLES (default 8) cycles, starting right after edge k, when noiseIn is low.
- R3: A falling edge of cmdIn, seen at edge k, drives linkReset high for exactly PULSE_CYCLES cycles, starting right after edge k, when noiseIn is low.
- R4: An edge of cmdIn ends any pulse still running on the opposite line in the same cycle. The two transmitted pulses are never high together.
- R5: A set (reset) pulse is accepted on its MIN_CYCLES-th (default 5) consecutive clean cycle. A clean cycle is one where its own line is high and the other line is low. When enabled, levelOut then becomes 1 (0) at the next edge, which is MIN_CYCLES edges after the pulse started.
- R6: A run of clean cycles shorter than MIN_CYCLES is discarded and leaves levelOut unchanged.
- R7: noiseIn high drives both linkSet and linkReset high. A cycle with both lines high is ignored and restarts both width counts from zero.
- R8: While rxEnable is low, levelOut is 0 and no pulse is accepted. After rxEnable rises, levelOut changes only at the first pulse accepted while enabled.
- R9: levelOut changes only on an accepted pulse or when rxEnable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdIn | input | 1 | Level command to be carried |
| noiseIn | input | 1 | Common-mode disturbance; raises both lines |
| rxEnable | input | 1 | Receive enable from supply monitoring |
| linkSet | output | 1 | Set pulse line as seen by the receiver |
| linkReset | output | 1 | Reset pulse line as seen by the receiver |
| levelOut | output | 1 | Rebuilt command level |

## Verification
The hardest case to reach is a valid pulse cut into pieces by noise. Whether it is accepted depends only on whether the clean stretch after the last noise cycle is still MIN_CYCLES long. The stimulus places one or two noise cycles at chosen offsets inside an 8-cycle set pulse, so that one case leaves a 5-cycle tail and is accepted and another leaves a 4-cycle tail and is rejected. A second hard case is an enable that rises in the middle of a pulse that is already running. The bench raises rxEnable two cycles into a pulse and expects the pulse to be accepted. A command held high across an enable transition must change nothing until a fresh edge arrives.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;

  // Strobes from the control to the datapath latch
  typedef struct packed {
    logic takeSet;     // accepted set pulse: drive level to 1
    logic takeReset;   // accepted reset pulse: drive level to 0
    logic clearLevel;  // receiver disabled: hold level at 0
  } linkStrobe_t;

  localparam int unsigned LINE_SET   = 0;
  localparam int unsigned LINE_RESET = 1;
  localparam int unsigned LINE_COUNT = 2;

endpackage

// File: rtl/edge_link_dp.sv
module edge_link_dp
  import edge_link_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8,
  parameter int unsigned MIN_CYCLES   = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdIn,
  input  logic        lineSetIn,
  input  logic        lineResetIn,
  input  linkStrobe_t strobe,
  output logic        txSet,
  output logic        txReset,
  output logic        setReady,
  output logic        resetReady,
  output logic        levelOut
);

  localparam int unsigned TX_W  = $clog2(PULSE_CYCLES + 1);
  localparam int unsigned RUN_W = $clog2(MIN_CYCLES + 1);
  localparam logic [TX_W-1:0]  TX_LOAD  = TX_W'(PULSE_CYCLES);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(MIN_CYCLES);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_CYCLES - 1);

  // ---------------- transmit side: edge detect and pulse timers -----------
  logic            cmdPrev;
  logic            cmdRise;
  logic            cmdFall;
  logic [TX_W-1:0] setTimer;
  logic [TX_W-1:0] resetTimer;

  assign cmdRise = cmdIn && !cmdPrev;
  assign cmdFall = !cmdIn && cmdPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPrev    <= 1'b0;
      setTimer   <= '0;
      resetTimer <= '0;
    end else begin
      cmdPrev <= cmdIn;
      if (cmdRise) begin
        setTimer   <= TX_LOAD;
        resetTimer <= '0;
      end else if (cmdFall) begin
        resetTimer <= TX_LOAD;
        setTimer   <= '0;
      end else begin
        if (setTimer != '0)   setTimer   <= setTimer - TX_W'(1);
        if (resetTimer != '0) resetTimer <= resetTimer - TX_W'(1);
      end
    end
  end

  assign txSet   = (setTimer != '0);
  assign txReset = (resetTimer != '0);

  // ---------------- receive side: per-line width discriminators ------------
  logic [LINE_COUNT-1:0] lineRaw;
  logic [LINE_COUNT-1:0] lineClean;
  logic [LINE_COUNT-1:0] lineReady;

  assign lineRaw[LINE_SET]   = lineSetIn;
  assign lineRaw[LINE_RESET] = lineResetIn;

  generate
    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_disc
      logic [RUN_W-1:0] runLen;
      // own line high while the other line is low
      assign lineClean[g] = lineRaw[g] && !lineRaw[LINE_COUNT-1-g];
      assign lineReady[g] = lineClean[g] && (runLen == RUN_LAST);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          runLen <= '0;
        end else if (!lineClean[g]) begin
          runLen <= '0;
        end else if (runLen != RUN_MAX) begin
          runLen <= runLen + RUN_W'(1);
        end
      end
    end
  endgenerate

  assign setReady   = lineReady[LINE_SET];
  assign resetReady = lineReady[LINE_RESET];

  // ---------------- output set/reset latch ---------------------------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelOut <= 1'b0;
    end else if (strobe.clearLevel) begin
      levelOut <= 1'b0;
    end else if (strobe.takeSet) begin
      levelOut <= 1'b1;
    end else if (strobe.takeReset) begin
      levelOut <= 1'b0;
    end
  end

endmodule

// File: rtl/edge_link_ctl.sv
module edge_link_ctl
  import edge_link_pkg::*;
(
  input  logic        rxEnable,
  input  logic        setReady,
  input  logic        resetReady,
  output linkStrobe_t strobe
);

  always_comb begin
    strobe            = '0;
    strobe.clearLevel = !rxEnable;
    if (rxEnable) begin
      if (setReady) begin
        strobe.takeSet = 1'b1;
      end else if (resetReady) begin
        strobe.takeReset = 1'b1;
      end
    end
  end

endmodule

// File: rtl/edge_link_top.sv
module edge_link_top
  import edge_link_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8,
  parameter int unsigned MIN_CYCLES   = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdIn,
  input  logic noiseIn,
  input  logic rxEnable,
  output logic linkSet,
  output logic linkReset,
  output logic levelOut
);

  logic        txSet;
  logic        txReset;
  logic        setReady;
  logic        resetReady;
  linkStrobe_t strobe;

  // common-mode disturbance lands on both lines at once
  assign linkSet   = txSet   || noiseIn;
  assign linkReset = txReset || noiseIn;

  edge_link_dp #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .MIN_CYCLES  (MIN_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmdIn      (cmdIn),
    .lineSetIn  (linkSet),
    .lineResetIn(linkReset),
    .strobe     (strobe),
    .txSet      (txSet),
    .txReset    (txReset),
    .setReady   (setReady),
    .resetReady (resetReady),
    .levelOut   (levelOut)
  );

  edge_link_ctl u_ctl (
    .rxEnable  (rxEnable),
    .setReady  (setReady),
    .resetReady(resetReady),
    .strobe    (strobe)
  );

endmodule

// File: rtl/edge_link_chk.sv
module edge_link_chk #(
  parameter int unsigned PULSE_CYCLES = 8,
  parameter int unsigned MIN_CYCLES   = 5
) (
  input logic clk,
  input logic rstN,
  input logic noiseIn,
  input logic rxEnable,
  input logic txSet,
  input logic txReset,
  input logic linkSet,
  input logic linkReset,
  input logic levelOut
);

  localparam int unsigned SAT = PULSE_CYCLES + MIN_CYCLES + 4;

  int unsigned setRunSeen;
  int unsigned resetRunSeen;
  int unsigned setHighLen;
  int unsigned resetHighLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setRunSeen   <= 0;
      resetRunSeen <= 0;
      setHighLen   <= 0;
      resetHighLen <= 0;
    end else begin
      setRunSeen   <= (linkSet && !linkReset) ? ((setRunSeen < SAT) ? setRunSeen + 1 : setRunSeen) : 0;
      resetRunSeen <= (linkReset && !linkSet) ? ((resetRunSeen < SAT) ? resetRunSeen + 1 : resetRunSeen) : 0;
      setHighLen   <= txSet ? ((setHighLen < SAT) ? setHighLen + 1 : setHighLen) : 0;
      resetHighLen <= txReset ? ((resetHighLen < SAT) ? resetHighLen + 1 : resetHighLen) : 0;
    end
  end

  AST_SET_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    txSet |-> setHighLen < PULSE_CYCLES);                            // R2
  AST_RESET_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    txReset |-> resetHighLen < PULSE_CYCLES);                        // R3
  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(txSet && txReset));                                            // R4
  AST_RISE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(levelOut) |-> setRunSeen >= MIN_CYCLES);                   // R5
  AST_FALL_ENABLED_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(levelOut) && $past(rxEnable)) |-> resetRunSeen >= MIN_CYCLES); // R6
  AST_NOISE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (noiseIn && rxEnable) |=> $stable(levelOut));                    // R7
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !levelOut);                                        // R8

endmodule

bind edge_link_top edge_link_chk #(
  .PULSE_CYCLES(PULSE_CYCLES),
  .MIN_CYCLES  (MIN_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .noiseIn  (noiseIn),
  .rxEnable (rxEnable),
  .txSet    (txSet),
  .txReset  (txReset),
  .linkSet  (linkSet),
  .linkReset(linkReset),
  .levelOut (levelOut)
);

// File: tb/edge_link_top_tb.sv
module edge_link_top_tb;

  localparam int PULSE = 8;
  localparam int MINW  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdIn = 1'b0;
  logic noiseIn = 1'b0;
  logic rxEnable = 1'b0;
  logic linkSet, linkReset, levelOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_link_top #(.PULSE_CYCLES(PULSE), .MIN_CYCLES(MINW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .noiseIn(noiseIn),
    .rxEnable(rxEnable), .linkSet(linkSet), .linkReset(linkReset),
    .levelOut(levelOut)
  );

  // ---------- behavioural reference: timers and run lengths as integers ----
  int  mSetLeft, mResetLeft, mSetRun, mResetRun;
  bit  mCmdPrev, mLevel;

  always @(posedge clk) begin
    bit sLine, rLine, sClean, rClean, accS, accR;
    if (!rstN) begin
      mSetLeft = 0; mResetLeft = 0; mSetRun = 0; mResetRun = 0;
      mCmdPrev = 0; mLevel = 0;
    end else begin
      sLine  = (mSetLeft > 0) || noiseIn;
      rLine  = (mResetLeft > 0) || noiseIn;
      sClean = sLine && !rLine;
      rClean = rLine && !sLine;
      accS   = sClean && (mSetRun + 1 >= MINW) && (mSetRun < MINW);
      accR   = rClean && (mResetRun + 1 >= MINW) && (mResetRun < MINW);
      if (!rxEnable) mLevel = 0;
      else if (accS) mLevel = 1;
      else if (accR) mLevel = 0;
      mSetRun   = sClean ? ((mSetRun < MINW) ? mSetRun + 1 : mSetRun) : 0;
      mResetRun = rClean ? ((mResetRun < MINW) ? mResetRun + 1 : mResetRun) : 0;
      if (cmdIn && !mCmdPrev) begin
        mSetLeft = PULSE; mResetLeft = 0;
      end else if (!cmdIn && mCmdPrev) begin
        mResetLeft = PULSE; mSetLeft = 0;
      end else begin
        if (mSetLeft > 0) mSetLeft--;
        if (mResetLeft > 0) mResetLeft--;
      end
      mCmdPrev = cmdIn;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    check(linkSet,   (mSetLeft > 0) || noiseIn,   "R2 R7 linkSet vs model");
    check(linkReset, (mResetLeft > 0) || noiseIn, "R3 R7 linkReset vs model");
    check(levelOut,  mLevel,                      "R9 levelOut vs model");
  endtask

  task automatic step(input logic c, input logic n, input logic e);
    @(negedge clk);
    compareModel();
    cmdIn = c; noiseIn = n; rxEnable = e;
  endtask

  task automatic hold(input int cyc);
    for (int i = 0; i < cyc; i++) step(cmdIn, 1'b0, rxEnable);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(levelOut, 1'b0, "R1 level in reset");
    check(linkSet, 1'b0, "R1 set line in reset");
    rstN = 1'b1;
    step(0, 0, 1);
    check(levelOut, 1'b0, "R1 level after reset");
    check(linkReset, 1'b0, "R1 reset line after reset");
    hold(3);

    // R5 and R2: rising edge, latency MIN edges, pulse length PULSE
    step(1, 0, 1);
    hold(5);
    check(levelOut, 1'b0, "R5 level before run complete");
    check(linkSet, 1'b1, "R2 set line active");
    hold(1);
    check(levelOut, 1'b1, "R5 level after accepted set");
    hold(2);
    check(linkSet, 1'b1, "R2 set line in last cycle");
    hold(1);
    check(linkSet, 1'b0, "R2 set line ended after PULSE");
    hold(4);

    // R3: falling edge sends reset pulse and clears level
    step(0, 0, 1);
    hold(6);
    check(linkReset, 1'b1, "R3 reset line active");
    check(levelOut, 1'b0, "R3 level after accepted reset");
    hold(6);

    // R7: noise alone, both lines high, level untouched
    step(0, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, 1);
    check(linkSet & linkReset, 1'b1, "R7 noise on both lines");
    step(0, 0, 1);
    hold(3);
    check(levelOut, 1'b0, "R7 level after noise burst");

    // R6 and R4: from level 1, 2-cycle low command yields short reset pulse
    step(1, 0, 1); hold(12);
    check(levelOut, 1'b1, "R6 setup level high");
    step(0, 0, 1); step(0, 0, 1); step(1, 0, 1);
    hold(1);
    check(linkReset, 1'b0, "R4 reset pulse cut by rise");
    for (int i = 0; i < 10; i++) begin
      hold(1);
      check(levelOut, 1'b1, "R6 short reset pulse discarded");
    end

    // R7: noise splits a set pulse; 5-cycle tail accepted
    step(0, 0, 1); hold(12);
    step(1, 0, 1); hold(2);
    step(1, 1, 1); step(1, 0, 1);
    hold(4);
    check(levelOut, 1'b0, "R7 broken run not yet accepted");
    hold(1);
    check(levelOut, 1'b1, "R7 tail of five accepted");
    hold(6);

    // R6/R7: noise leaves only 4-cycle tail on a reset pulse; rejected
    step(0, 0, 1); hold(2);
    step(0, 1, 1); step(0, 1, 1); step(0, 0, 1);
    hold(10);
    check(levelOut, 1'b1, "R6 four-cycle tail rejected");

    // R8: disable clears, pulses ignored, first enabled pulse decides
    step(cmdIn, 0, 0);
    hold(2);
    check(levelOut, 1'b0, "R8 disabled level low");
    step(0, 0, 0); hold(2);
    step(1, 0, 0); hold(12);
    check(levelOut, 1'b0, "R8 set ignored while disabled");
    step(1, 0, 1); hold(10);
    check(levelOut, 1'b0, "R8 no change without new edge");
    step(0, 0, 1); hold(12);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 1);
    hold(6);
    check(levelOut, 1'b1, "R8 pulse running at enable accepted");
    hold(6);

    // R9: long quiet stretch with command toggling accepted each time
    for (int k = 0; k < 4; k++) begin
      step(k % 2 == 0 ? 1'b0 : 1'b1, 0, 1);
      hold(11);
      check(levelOut, (k % 2 == 0) ? 1'b0 : 1'b1, "R9 level follows edges");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule